// File: doc/BRIEF.md
# Flash Command and Status Sequencer

This block models the command side of a small parallel NOR-style flash array. A host drives synchronous bus cycles through active-low chip enable, write enable and output enable, with an address and a data byte. Writes pass through an unlock-prefixed command decoder that recognises byte program, sector erase and a return-to-read command. A simulated embedded algorithm then programs one byte or erases a set of sectors in a small internal array. While that algorithm runs, the block answers reads with a status byte in place of array data.

Sector erase is two-phased. Once the first erase command is complete, the block opens a timed collection window. Further single-cycle sector selections written during the window join the erase set. When the window closes, the erase proper runs and ignores every write until it is done. Both kinds of operation count cycles against a pulse limit. A program that tries to raise a bit from 0 to 1 can never finish. It ends in a sticky timeout state that only the return-to-read command clears. A per-sector lock bitmap input blocks program and erase of chosen sectors.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `rdata` is 00h and the block is in read-array mode. A hardware reset during an operation abandons it, and the next read returns the unchanged array byte.
- R2: A bus write is taken only in a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. Every other combination leaves the command decoder unchanged. A read is a cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1, and it loads `rdata` at that clock edge.
- R3: Commands need the prefix AAh at address 555h and then 55h at 2AAh, compared on address bits 11:0. Any write that does not fit the expected step returns the decoder to idle.
- R4: The sequence prefix, then A0h at 555h, then a data write programs that byte at that address. After completion, reads return the data. Programming that only clears bits always succeeds.
- R5: While an operation runs, a read returns a status byte. Bit 7 is the complement of bit 7 of the target data, and is 0 for an erase. Bit 6 is 0 on the first status read and inverts on every later read. Bit 5 is the timeout flag. Bit 3 is the erase-running flag. Bits 4, 2, 1 and 0 are 0.
- R6: The prefix, then 80h at 555h, then the prefix again, then 30h at an address in sector s opens the erase window with bit 3 = 0. During the window, a single write of 30h at an address in another sector adds that sector to the erase set.
- R7: When the window expires, bit 3 reads 1 and the erase runs. All writes are ignored until it ends. Each byte of the selected sectors then reads FFh, and the other sectors are unchanged.
- R8: Programming a 1 over a stored 0 never completes. Bit 7 never matches the data, bit 6 keeps toggling, and bit 5 becomes 1 once the pulse limit has been counted.
- R9: In the timeout state the block returns status on every read and ignores every command except F0h. A write of F0h returns it to read mode with the array unchanged.
- R10: A program or erase aimed at a sector whose `lock_map` bit is 1 is dropped and starts no operation. A locked sector written as 30h during the window is not added to the set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | BUS_AW | Bus address; the low bits index the array |
| wdata | input | 8 | Write data or command byte |
| lock_map | input | SECTORS | Per-sector lock, 1 blocks program and erase |
| rdata | output | 8 | Array byte or status byte from the last read |

## Verification
The assertions take for granted that a bus cycle is either a clean write or a clean read. They also assume that the pulse limit is at least as long as the erase time, so that an erase never times out, and that `lock_map` only changes while no operation runs. The bench holds each bus cycle for one clock with an idle clock after it. It changes the lock bitmap only once a poll has shown read mode. It keeps the parameter defaults, which put the erase length well inside the pulse limit. Every sweep over the array starts from a fully erased state, so the bench model of the array content is known at each step.

// File: rtl/fseq_pkg.sv
// Shared types and command codes for the flash command sequencer.
// Assumes a bus address of at least 12 bits for the unlock addresses.
package fseq_pkg;
    typedef enum logic [2:0] {
        ALG_READ, ALG_WINDOW, ALG_ERASE, ALG_PROG, ALG_TIMEOUT
    } alg_state_e;

    typedef enum logic [2:0] {
        DEC_IDLE, DEC_UNL1, DEC_UNL2, DEC_PDATA, DEC_ERA1, DEC_ERA2, DEC_ERA3
    } dec_state_e;

    localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
    localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  OP_PROGRAM    = 8'hA0;
    localparam logic [7:0]  OP_ERASE_PREP = 8'h80;
    localparam logic [7:0]  OP_SECTOR     = 8'h30;
    localparam logic [7:0]  OP_TO_READ    = 8'hF0;
endpackage

// File: rtl/fseq_cmd_decode.sv
// Unlock-prefixed command decoder. It steps through the write sequence and
// emits one-cycle program and erase requests in the cycle of the final write.
// Assumes enable is high only while the algorithm is idle; when enable is low
// the decoder is held idle.
module fseq_cmd_decode
    import fseq_pkg::*;
#(
    parameter int BUS_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_q,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output dec_state_e        dec_st,
    output logic              prog_go,
    output logic              erase_go,
    output logic              reset_go
);
    dec_state_e nxt;
    logic       at_a;
    logic       at_b;

    assign at_a     = (addr[11:0] == UNLOCK_ADDR_A);
    assign at_b     = (addr[11:0] == UNLOCK_ADDR_B);
    assign reset_go = wr_q && (wdata == OP_TO_READ);

    // Next-step selection for the command sequence.
    always_comb begin
        nxt      = dec_st;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        if (!enable) begin
            nxt = DEC_IDLE;
        end else if (wr_q) begin
            nxt = DEC_IDLE;
            case (dec_st)
                DEC_IDLE: if (at_a && wdata == KEY_FIRST)  nxt = DEC_UNL1;
                DEC_UNL1: if (at_b && wdata == KEY_SECOND) nxt = DEC_UNL2;
                DEC_UNL2: begin
                    if (at_a && wdata == OP_PROGRAM)         nxt = DEC_PDATA;
                    else if (at_a && wdata == OP_ERASE_PREP) nxt = DEC_ERA1;
                end
                DEC_PDATA: prog_go = 1'b1;
                DEC_ERA1: if (at_a && wdata == KEY_FIRST)  nxt = DEC_ERA2;
                DEC_ERA2: if (at_b && wdata == KEY_SECOND) nxt = DEC_ERA3;
                DEC_ERA3: erase_go = (wdata == OP_SECTOR);
                default:  nxt = DEC_IDLE;
            endcase
        end
    end

    // Decoder state register.
    always_ff @(posedge clk) begin
        if (!rst_n) dec_st <= DEC_IDLE;
        else        dec_st <= nxt;
    end
endmodule

// File: rtl/fseq_algo.sv
// Embedded program/erase engine. It holds the erase window, the pulse counter,
// the erase set and the status byte, and drives the array write strobes.
// Assumes PROG_CYC and ERASE_CYC do not exceed PULSE_LIMIT, WINDOW_CYC >= 2,
// and a power-of-two sector count.
module fseq_algo
    import fseq_pkg::*;
#(
    parameter int SECTORS     = 4,
    parameter int SECT_BYTES  = 16,
    parameter int WINDOW_CYC  = 32,
    parameter int PROG_CYC    = 4,
    parameter int ERASE_CYC   = 20,
    parameter int PULSE_LIMIT = 48,
    localparam int SEC_AW     = $clog2(SECT_BYTES),
    localparam int SID_W      = $clog2(SECTORS),
    localparam int ARR_AW     = SID_W + SEC_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_q,
    input  logic              rd_q,
    input  logic [ARR_AW-1:0] arr_addr,
    input  logic [7:0]        wdata,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic              reset_go,
    input  logic [SECTORS-1:0] lock_map,
    input  logic [7:0]        tgt_old,
    output alg_state_e        st,
    output logic [7:0]        status,
    output logic [ARR_AW-1:0] tgt_addr,
    output logic [7:0]        tgt_data,
    output logic              pg_we,
    output logic              er_we,
    output logic [SECTORS-1:0] er_mask
);
    localparam int CNT_W = $clog2(PULSE_LIMIT + 1);
    localparam int WIN_W = $clog2(WINDOW_CYC);

    logic [CNT_W-1:0]   pcnt;
    logic [WIN_W-1:0]   wcnt;
    logic               tgl;
    logic               op_erase;
    logic [SID_W-1:0]   sec_id;
    logic [SECTORS-1:0] sec_bit;
    logic               sec_locked;
    logic               blank_ok;
    logic               hit_limit;

    assign sec_id     = arr_addr[ARR_AW-1:SEC_AW];
    assign sec_bit    = SECTORS'(1) << sec_id;
    assign sec_locked = lock_map[sec_id];
    assign blank_ok   = ((~tgt_old & tgt_data) == 8'h00);
    assign hit_limit  = (pcnt == CNT_W'(PULSE_LIMIT - 1));
    assign pg_we      = (st == ALG_PROG) && blank_ok && (pcnt == CNT_W'(PROG_CYC - 1));
    assign er_we      = (st == ALG_ERASE) && (pcnt == CNT_W'(ERASE_CYC - 1));

    // Status byte presented while an operation is active.
    assign status = {~tgt_data[7], tgl, (st == ALG_TIMEOUT), 1'b0,
                     (st == ALG_ERASE) || (st == ALG_TIMEOUT && op_erase), 3'b000};

    // Operation state, counters, target and erase set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ALG_READ;
            pcnt     <= '0;
            wcnt     <= '0;
            er_mask  <= '0;
            tgt_addr <= '0;
            tgt_data <= 8'h00;
            op_erase <= 1'b0;
        end else begin
            case (st)
                ALG_READ: begin
                    if (prog_go && !sec_locked) begin
                        st       <= ALG_PROG;
                        pcnt     <= '0;
                        tgt_addr <= arr_addr;
                        tgt_data <= wdata;
                        op_erase <= 1'b0;
                    end else if (erase_go && !sec_locked) begin
                        st       <= ALG_WINDOW;
                        wcnt     <= '0;
                        er_mask  <= sec_bit;
                        tgt_data <= 8'hFF;
                        op_erase <= 1'b1;
                    end
                end
                ALG_WINDOW: begin
                    if (wr_q && wdata == OP_SECTOR && !sec_locked)
                        er_mask <= er_mask | sec_bit;
                    if (wcnt == WIN_W'(WINDOW_CYC - 1)) begin
                        st   <= ALG_ERASE;
                        pcnt <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ALG_ERASE: begin
                    if (er_we)          st <= ALG_READ;
                    else if (hit_limit) st <= ALG_TIMEOUT;
                    else                pcnt <= pcnt + 1'b1;
                end
                ALG_PROG: begin
                    if (pg_we)          st <= ALG_READ;
                    else if (hit_limit) st <= ALG_TIMEOUT;
                    else                pcnt <= pcnt + 1'b1;
                end
                ALG_TIMEOUT: if (reset_go) st <= ALG_READ;
                default: st <= ALG_READ;
            endcase
        end
    end

    // Toggle bit: cleared in read mode, inverted on each status read.
    always_ff @(posedge clk) begin
        if (!rst_n)             tgl <= 1'b0;
        else if (st == ALG_READ) tgl <= 1'b0;
        else if (rd_q)          tgl <= ~tgl;
    end
endmodule

// File: rtl/fseq_array.sv
// Byte array with a single-byte program port, a whole-sector erase port and
// two combinational read ports. Contents are not reset, as in a real array;
// the host erases before first use.
module fseq_array #(
    parameter int SECTORS    = 4,
    parameter int SECT_BYTES = 16,
    localparam int SEC_AW    = $clog2(SECT_BYTES),
    localparam int ARR_AW    = $clog2(SECTORS) + SEC_AW,
    localparam int DEPTH     = SECTORS * SECT_BYTES
) (
    input  logic               clk,
    input  logic               pg_we,
    input  logic [ARR_AW-1:0]  pg_addr,
    input  logic [7:0]         pg_data,
    input  logic               er_we,
    input  logic [SECTORS-1:0] er_mask,
    input  logic [ARR_AW-1:0]  rd_addr_a,
    output logic [7:0]         rd_data_a,
    input  logic [ARR_AW-1:0]  rd_addr_b,
    output logic [7:0]         rd_data_b
);
    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] byte_er;

    // Per-byte erase strobe from the sector mask.
    for (genvar g = 0; g < DEPTH; g++) begin : g_er
        assign byte_er[g] = er_we && er_mask[g / SECT_BYTES];
    end

    // Array update: erase sets bytes to FFh, program writes one byte.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (byte_er[i])
                mem[i] <= 8'hFF;
            else if (pg_we && pg_addr == ARR_AW'(i))
                mem[i] <= pg_data;
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command and status sequencer. It qualifies bus cycles,
// wires the decoder, engine and array, and registers the read data.
// Assumes one clean bus cycle per clock and BUS_AW >= 12.
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int BUS_AW      = 12,
    parameter int SECTORS     = 4,
    parameter int SECT_BYTES  = 16,
    parameter int WINDOW_CYC  = 32,
    parameter int PROG_CYC    = 4,
    parameter int ERASE_CYC   = 20,
    parameter int PULSE_LIMIT = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic [BUS_AW-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic [SECTORS-1:0] lock_map,
    output logic [7:0]         rdata
);
    localparam int ARR_AW = $clog2(SECTORS) + $clog2(SECT_BYTES);

    logic               wr_q;
    logic               rd_q;
    dec_state_e         dec_st;
    alg_state_e         alg_st;
    logic               prog_go;
    logic               erase_go;
    logic               reset_go;
    logic [7:0]         status;
    logic [ARR_AW-1:0]  tgt_addr;
    logic [7:0]         tgt_data;
    logic [7:0]         tgt_old;
    logic [7:0]         arr_rd;
    logic               pg_we;
    logic               er_we;
    logic [SECTORS-1:0] er_mask;

    assign wr_q = !ce_n && !we_n && oe_n;
    assign rd_q = !ce_n && !oe_n && we_n;

    fseq_cmd_decode #(.BUS_AW(BUS_AW)) dec_i (
        .clk(clk), .rst_n(rst_n), .enable(alg_st == ALG_READ), .wr_q(wr_q),
        .addr(addr), .wdata(wdata), .dec_st(dec_st), .prog_go(prog_go),
        .erase_go(erase_go), .reset_go(reset_go)
    );

    fseq_algo #(
        .SECTORS(SECTORS), .SECT_BYTES(SECT_BYTES), .WINDOW_CYC(WINDOW_CYC),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PULSE_LIMIT(PULSE_LIMIT)
    ) algo_i (
        .clk(clk), .rst_n(rst_n), .wr_q(wr_q), .rd_q(rd_q),
        .arr_addr(addr[ARR_AW-1:0]), .wdata(wdata), .prog_go(prog_go),
        .erase_go(erase_go), .reset_go(reset_go), .lock_map(lock_map),
        .tgt_old(tgt_old), .st(alg_st), .status(status), .tgt_addr(tgt_addr),
        .tgt_data(tgt_data), .pg_we(pg_we), .er_we(er_we), .er_mask(er_mask)
    );

    fseq_array #(.SECTORS(SECTORS), .SECT_BYTES(SECT_BYTES)) arr_i (
        .clk(clk), .pg_we(pg_we), .pg_addr(tgt_addr), .pg_data(tgt_data),
        .er_we(er_we), .er_mask(er_mask), .rd_addr_a(addr[ARR_AW-1:0]),
        .rd_data_a(arr_rd), .rd_addr_b(tgt_addr), .rd_data_b(tgt_old)
    );

    // Read data register: array byte in read mode, status byte otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= 8'h00;
        else if (rd_q) rdata <= (alg_st == ALG_READ) ? arr_rd : status;
    end
endmodule

// File: rtl/fseq_checker.sv
// Property checker for the flash command sequencer, bound to the top.
// Assumes clean bus cycles and an erase length inside the pulse limit.
module fseq_checker
    import fseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input alg_state_e alg_st,
    input dec_state_e dec_st
);
    logic wr_c;
    logic rd_c;
    assign wr_c = !ce_n && !we_n && oe_n;
    assign rd_c = !ce_n && !oe_n && we_n;

    // R2
    no_write_dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c |=> $stable(dec_st));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_c |=> $stable(rdata));

    // R6
    window_bit3_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_st == ALG_WINDOW && rd_c) |=> (!rdata[3] && !rdata[7]));

    // R7
    erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_st == ALG_ERASE && rd_c) |=> (rdata[3] && !rdata[7] && !rdata[5]));

    // R7
    erase_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_st == ALG_ERASE) |=> (dec_st == DEC_IDLE));

    // R9
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_st == ALG_TIMEOUT && !(wr_c && wdata == OP_TO_READ)) |=> (alg_st == ALG_TIMEOUT));

    // R9
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alg_st == ALG_TIMEOUT && rd_c) |=> rdata[5]);
endmodule

bind flash_cmd_seq fseq_checker chk_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .alg_st(alg_st), .dec_st(dec_st)
);

// File: tb/flash_cmd_seq_tb.sv
// Self-checking bench: sweeps program and erase over the whole array and
// tracks expected contents in a local model.
module flash_cmd_seq_tb_top;
    localparam int SECT_BYTES = 16;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  lock_map = '0;
    logic [7:0]  rdata;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mem_m [DEPTH];
    logic [7:0] r;

    always #10 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .lock_map(lock_map), .rdata(rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d,
                          input logic [2:0] cwo = 3'b001);
        @(negedge clk);
        addr = a; wdata = d; {ce_n, we_n, oe_n} = cwo;
        @(negedge clk);
        {ce_n, we_n, oe_n} = 3'b111;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; {ce_n, we_n, oe_n} = 3'b010;
        @(negedge clk);
        v = rdata;
        {ce_n, we_n, oe_n} = 3'b111;
    endtask

    task automatic prog_cmd(input logic [11:0] a, input logic [7:0] d);
        bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55);
        bus_wr(12'h555, 8'hA0); bus_wr(a, d);
    endtask

    task automatic erase_cmd(input int sec);
        bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55); bus_wr(12'h555, 8'h80);
        bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55);
        bus_wr(12'(sec * SECT_BYTES), 8'h30);
    endtask

    // Poll one address until it returns the expected byte (bounded).
    task automatic poll(input string req, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] v;
        for (int k = 0; k < 200; k++) begin
            bus_rd(a, v);
            if (v == exp) break;
        end
        chk(req, v, exp);
    endtask

    task automatic sweep(input string req);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            bus_rd(12'(i), v);
            chk(req, v, mem_m[i]);
        end
    endtask

    initial begin
        #(20ns * 150000);
        miscompares++;
        $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] v, v2, d;
        int reads;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rdata", rdata, 8'h00);

        // Erase everything: first sector through the full sequence, the rest in the window.
        erase_cmd(0);
        bus_rd(12'h000, v);
        chk("R5/R6 window status", v, 8'h00);
        bus_rd(12'h000, v);
        chk("R5 toggle second read", v, 8'h40);
        for (int s = 1; s < 4; s++) bus_wr(12'(s * SECT_BYTES), 8'h30);
        for (int k = 0; k < 100; k++) begin
            bus_rd(12'h000, v);
            if (v[3]) break;
        end
        chk("R7 bit3 set after window", v & 8'h08, 8'h08);
        poll("R7 erase done", 12'h000, 8'hFF);
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        sweep("R7 all erased");

        // Program sweep over every byte.
        for (int i = 0; i < DEPTH; i++) begin
            d = 8'((i * 37 + 5) & 8'hFF);
            prog_cmd(12'(i), d);
            if (i == 0) begin
                bus_rd(12'(i), v);
                chk("R5 program status", v, {~d[7], 7'b0});
            end
            poll("R4 program", 12'(i), d);
            mem_m[i] = d;
        end
        sweep("R4 programmed array");

        // Second pass clearing bits only.
        for (int i = 0; i < DEPTH; i += 3) begin
            d = mem_m[i] & 8'((i * 11 + 3) & 8'hFF);
            prog_cmd(12'(i), d);
            poll("R4 bit clear", 12'(i), d);
            mem_m[i] = d;
        end

        // Write qualification: the first unlock write uses a non-write combination.
        for (int c = 0; c < 8; c++) begin
            if (c == 1) continue;
            bus_wr(12'h555, 8'hAA, 3'(c));
            bus_wr(12'h2AA, 8'h55); bus_wr(12'h555, 8'hA0); bus_wr(12'h005, 8'h00);
            bus_rd(12'h005, v);
            chk("R2 inhibited write", v, mem_m[5]);
        end

        // Broken sequences.
        bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55); bus_wr(12'h555, 8'h55);
        bus_wr(12'h555, 8'hA0); bus_wr(12'h006, 8'h00);
        bus_rd(12'h006, v);
        chk("R3 wrong third step", v, mem_m[6]);
        bus_wr(12'h555, 8'hAA); bus_wr(12'h2AB, 8'h55);
        bus_wr(12'h555, 8'hA0); bus_wr(12'h007, 8'h00);
        bus_rd(12'h007, v);
        chk("R3 wrong unlock address", v, mem_m[7]);

        // Locked sector 2: program and erase are dropped.
        lock_map = 4'b0100;
        prog_cmd(12'h021, 8'h00);
        bus_rd(12'h021, v);
        chk("R10 locked program", v, mem_m[33]);
        erase_cmd(2);
        bus_rd(12'h020, v);
        chk("R10 locked erase", v, mem_m[32]);

        // Erase sector 1 with sector 2 (locked) and 3 queued; later writes are ignored.
        erase_cmd(1);
        bus_wr(12'h020, 8'h30);
        bus_wr(12'h030, 8'h30);
        for (int k = 0; k < 100; k++) begin
            bus_rd(12'h010, v);
            if (v[3]) break;
        end
        chk("R7 erase running status", v & 8'hA8, 8'h08);
        bus_wr(12'h000, 8'h30);
        prog_cmd(12'h001, 8'h00);
        poll("R7 erase complete", 12'h010, 8'hFF);
        for (int i = 16; i < 32; i++) mem_m[i] = 8'hFF;
        for (int i = 48; i < 64; i++) mem_m[i] = 8'hFF;
        lock_map = 4'b0000;
        sweep("R7/R10 partial erase");

        // Non-blank program: byte 16 set to 00h then programmed with FFh.
        prog_cmd(12'h010, 8'h00);
        poll("R4 program zero", 12'h010, 8'h00);
        mem_m[16] = 8'h00;
        prog_cmd(12'h010, 8'hFF);
        reads = 0;
        v2 = 8'h00;
        for (int k = 0; k < 100; k++) begin
            bus_rd(12'h010, v);
            chk("R8 bit7 and bit6", v & 8'hC0, {1'b0, 1'(reads % 2), 6'b0});
            reads++;
            if (k == 0) chk("R8 no early timeout", v & 8'h20, 8'h00);
            if (v[5]) break;
        end
        chk("R8 timeout flagged", v & 8'h20, 8'h20);
        prog_cmd(12'h011, 8'h12);
        bus_rd(12'h011, v);
        chk("R9 status only in timeout", v & 8'hA0, 8'h20);
        bus_wr(12'h000, 8'hF0);
        bus_rd(12'h010, v);
        chk("R9 read mode after F0", v, 8'h00);
        bus_rd(12'h011, v);
        chk("R9 ignored program", v, mem_m[17]);

        // Hardware reset during an erase window.
        erase_cmd(0);
        bus_rd(12'h000, v);
        chk("R6 window open", v & 8'h08, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(12'h000, v);
        chk("R1 read mode after reset", v, mem_m[0]);
        repeat (80) @(negedge clk);
        bus_rd(12'h002, v);
        chk("R1 erase abandoned", v, mem_m[2]);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule